// File: doc/BRIEF.md
# Three-Phase Sine PWM Generator

This block turns a digital amplitude word and a rotor-angle estimate into three sine-weighted PWM enables, one for the high-side switch of each motor phase. The three enables come before dead-time insertion. A shared symmetric triangular carrier, 6 bits deep, runs with a fixed period of 252 clocks. Each phase has its own comparator, which sets its enable while the carrier is below that phase's duty value.

The rotor angle is given as an electrical sector (0..5) and a 5-bit position inside the sector. A 5-bit lead-angle code advances the applied waveform, and two limit inputs clamp that code before use. One quarter-wave sine table serves all three phases. The phases read it at angles 120 electrical degrees apart. New duty values and the drive mode are taken in only at the carrier valley, so no pulse is cut short or doubled mid-period.

A small amplitude puts the block into a refresh mode. In refresh mode no sine drive is applied, and a low-side refresh enable pulses once per carrier period with a short fixed width, which keeps bootstrap capacitors charged. An amplitude of zero turns every output off.

Top module: `spwm3_gen`

## Requirements
- R1: The carrier counts 0 up to 63 and back down to 0. Each value is held for two clocks. One full period lasts exactly 252 clocks, and the `carrier` port shows the current value.
- R2: Angles are in units of 1/192 electrical revolution (1.875 degrees). The base angle is sector*32 + position + effective lead, taken modulo 192. Phase U uses the base angle, phase V uses the base angle minus 64 units, and phase W uses the base angle minus 128 units.
- R3: In drive mode, the duty of a phase is 32 + floor(amp*m/512) while its angle is below 96 units, and 32 - floor(amp*m/512) otherwise. Here m is a quarter-wave sine with full scale 254, giving 0, 127, 220 and 254 at 0, 30, 60 and 90 degrees. An enable is high while the carrier is below its duty, so a duty d in 1..63 gives 4d-2 high clocks per period.
- R4: When the lower lead limit is greater than the upper limit, the effective lead code equals the lower limit. Otherwise the lead code is clamped into [lower, upper].
- R5: An effective lead code k advances every phase by k units, so code 31 gives 58.1 degrees.
- R6: Amplitude, angle and lead inputs are sampled only at the carrier valley, on the second clock at value 0. A change made during a period does not alter the outputs before the next valley.
- R7: An amplitude of 0 forces all three high-side enables and the refresh enable low.
- R8: An amplitude from 1 to 7 selects refresh mode. In refresh mode all high-side enables stay low and the refresh enable is high while the carrier is below 6, which is 22 of 252 clocks (about 8.7%). An amplitude of 8 or more selects drive mode, with the refresh enable low.
- R9: While reset is asserted, all enables are low and the carrier reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp_cmd | input | 6 | Amplitude word; also selects the off, refresh or drive mode |
| lead_code | input | 5 | Requested lead-angle code |
| lead_lo | input | 5 | Lower clamp for the lead code |
| lead_hi | input | 5 | Upper clamp for the lead code |
| sector | input | 3 | Electrical sector, 0..5 |
| sector_pos | input | 5 | Position within the sector, 0..31 |
| hs_en_u | output | 1 | High-side PWM enable, phase U |
| hs_en_v | output | 1 | High-side PWM enable, phase V |
| hs_en_w | output | 1 | High-side PWM enable, phase W |
| ls_refresh | output | 1 | Low-side refresh enable for bootstrap charging |
| carrier | output | 6 | Current triangular carrier value |

## Verification
The bench builds the block with its default parameters: a 6-bit carrier, a 6-bit amplitude, a refresh band below 8 and a refresh width of 6. With these values one carrier period is only 252 clocks, so every scenario can wait two full periods and then count the high clocks over one exact period. That count equals 4d-2 without regard to pipeline delay. The test angles are chosen so that each phase lands on a multiple of 30 degrees, where the table values are exact. With these angles, the lead clamp, the sector wraparound, the lead span, the amplitude scaling and the edges of the refresh band can all be predicted by hand.

// File: rtl/spwm3_pkg.sv
package spwm3_pkg;

  localparam int ANG_W       = 8;
  localparam int ANG_SECTOR  = 32;
  localparam int ANG_QUARTER = 48;
  localparam int ANG_HALF    = 2 * ANG_QUARTER;
  localparam int ANG_3Q      = 3 * ANG_QUARTER;
  localparam int ANG_FULL    = 4 * ANG_QUARTER;
  localparam int POS_W       = 5;
  localparam int LEAD_W      = 5;
  localparam int SECT_W      = 3;
  localparam int SINE_W      = 8;
  localparam int IDX_W       = 6;

  typedef logic [ANG_W-1:0] angle_t;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_REFRESH = 2'd1,
    MODE_DRIVE   = 2'd2
  } drive_mode_e;

  // Quarter-wave sine, full scale 254, step 1.875 degrees (index 0..48).
  function automatic logic [SINE_W-1:0] sine_quarter(input logic [IDX_W-1:0] idx);
    logic [SINE_W-1:0] v;
    case (idx)
      6'd0:  v = 8'd0;    6'd1:  v = 8'd8;    6'd2:  v = 8'd17;   6'd3:  v = 8'd25;
      6'd4:  v = 8'd33;   6'd5:  v = 8'd41;   6'd6:  v = 8'd50;   6'd7:  v = 8'd58;
      6'd8:  v = 8'd66;   6'd9:  v = 8'd74;   6'd10: v = 8'd82;   6'd11: v = 8'd89;
      6'd12: v = 8'd97;   6'd13: v = 8'd105;  6'd14: v = 8'd112;  6'd15: v = 8'd120;
      6'd16: v = 8'd127;  6'd17: v = 8'd134;  6'd18: v = 8'd141;  6'd19: v = 8'd148;
      6'd20: v = 8'd155;  6'd21: v = 8'd161;  6'd22: v = 8'd167;  6'd23: v = 8'd174;
      6'd24: v = 8'd180;  6'd25: v = 8'd185;  6'd26: v = 8'd191;  6'd27: v = 8'd196;
      6'd28: v = 8'd202;  6'd29: v = 8'd206;  6'd30: v = 8'd211;  6'd31: v = 8'd216;
      6'd32: v = 8'd220;  6'd33: v = 8'd224;  6'd34: v = 8'd228;  6'd35: v = 8'd231;
      6'd36: v = 8'd235;  6'd37: v = 8'd238;  6'd38: v = 8'd241;  6'd39: v = 8'd243;
      6'd40: v = 8'd245;  6'd41: v = 8'd247;  6'd42: v = 8'd249;  6'd43: v = 8'd251;
      6'd44: v = 8'd252;  6'd45: v = 8'd253;  6'd46: v = 8'd253;  6'd47: v = 8'd254;
      6'd48: v = 8'd254;
      default: v = 8'd0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/spwm3_carrier.sv
module spwm3_carrier #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             valley_load
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic             half_q, half_d;
  logic             step_en;

  // Each carrier value spans two clocks: the count advances on odd clocks.
  assign step_en = half_q;

  always_comb begin
    half_d = ~half_q;
    cnt_d  = cnt_q;
    up_d   = up_q;
    if (step_en) begin
      if (up_q) begin
        if (cnt_q == CNT_TOP) begin
          up_d  = 1'b0;
          cnt_d = cnt_q - CNT_ONE;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end else begin
        if (cnt_q == CNT_ONE) begin
          up_d = 1'b1;
        end
        cnt_d = cnt_q - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      up_q   <= up_d;
      half_q <= half_d;
    end
  end

  assign cnt         = cnt_q;
  assign valley_load = (cnt_q == '0) && half_q;

  // R1: the carrier moves by at most one step per clock
  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_ONE) ||
    (cnt_q == $past(cnt_q) - CNT_ONE));

  // R1: a value that has just changed holds for the next clock
  a_r1_two_clock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |=> $stable(cnt_q));

endmodule

// File: rtl/spwm3_lead_sel.sv
module spwm3_lead_sel #(
  parameter int LEAD_W = 5
) (
  input  logic [LEAD_W-1:0] code,
  input  logic [LEAD_W-1:0] lim_lo,
  input  logic [LEAD_W-1:0] lim_hi,
  output logic [LEAD_W-1:0] eff
);

  always_comb begin
    if (lim_lo > lim_hi) begin
      eff = lim_lo;
    end else if (code < lim_lo) begin
      eff = lim_lo;
    end else if (code > lim_hi) begin
      eff = lim_hi;
    end else begin
      eff = code;
    end
  end

endmodule

// File: rtl/spwm3_phase_duty.sv
module spwm3_phase_duty
  import spwm3_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int AMP_W  = 6,
  parameter int OFFSET = 0
) (
  input  angle_t           base,
  input  logic [AMP_W-1:0] amp,
  output logic [CNT_W:0]   duty
);

  localparam int          PROD_W = AMP_W + SINE_W;
  localparam int          SHIFT  = AMP_W + SINE_W + 1 - CNT_W;
  localparam logic [CNT_W:0] MID = (CNT_W+1)'(1 << (CNT_W - 1));

  logic [ANG_W:0]      sum;
  angle_t              ang;
  logic [IDX_W-1:0]    idx;
  logic                neg;
  logic [SINE_W-1:0]   mag;
  logic [PROD_W-1:0]   prod;
  logic [CNT_W:0]      half_amp;

  always_comb begin
    sum = {1'b0, base} + (ANG_W+1)'(OFFSET);
    if (sum >= (ANG_W+1)'(ANG_FULL)) begin
      ang = ANG_W'(sum - (ANG_W+1)'(ANG_FULL));
    end else begin
      ang = ANG_W'(sum);
    end
  end

  always_comb begin
    if (ang < ANG_W'(ANG_QUARTER)) begin
      idx = IDX_W'(ang);
      neg = 1'b0;
    end else if (ang < ANG_W'(ANG_HALF)) begin
      idx = IDX_W'(ANG_W'(ANG_HALF) - ang);
      neg = 1'b0;
    end else if (ang < ANG_W'(ANG_3Q)) begin
      idx = IDX_W'(ang - ANG_W'(ANG_HALF));
      neg = 1'b1;
    end else begin
      idx = IDX_W'(ANG_W'(ANG_FULL) - ang);
      neg = 1'b1;
    end
  end

  assign mag      = sine_quarter(idx);
  assign prod     = PROD_W'(amp) * PROD_W'(mag);
  assign half_amp = (CNT_W+1)'(prod >> SHIFT);
  assign duty     = neg ? (MID - half_amp) : (MID + half_amp);

endmodule

// File: rtl/spwm3_gen.sv
module spwm3_gen
  import spwm3_pkg::*;
#(
  parameter int CNT_W        = 6,
  parameter int AMP_W        = 6,
  parameter int REFRESH_TOP  = 8,
  parameter int REFRESH_DUTY = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AMP_W-1:0]  amp_cmd,
  input  logic [LEAD_W-1:0] lead_code,
  input  logic [LEAD_W-1:0] lead_lo,
  input  logic [LEAD_W-1:0] lead_hi,
  input  logic [SECT_W-1:0] sector,
  input  logic [POS_W-1:0]  sector_pos,
  output logic              hs_en_u,
  output logic              hs_en_v,
  output logic              hs_en_w,
  output logic              ls_refresh,
  output logic [CNT_W-1:0]  carrier
);

  localparam int NPH    = 3;
  localparam int DUTY_W = CNT_W + 1;
  localparam int SUM_W  = ANG_W + 1;

  logic [CNT_W-1:0]              cnt;
  logic                          valley_load;
  logic [LEAD_W-1:0]             lead_eff;
  logic [SUM_W-1:0]              base_sum;
  angle_t                        base_ang;
  logic [NPH-1:0][DUTY_W-1:0]    duty_new;
  logic [NPH-1:0][DUTY_W-1:0]    duty_q, duty_d;
  drive_mode_e                   mode_new, mode_q, mode_d;
  logic [NPH-1:0]                hs_q, hs_d;
  logic                          ls_q, ls_d;

  spwm3_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt         (cnt),
    .valley_load (valley_load)
  );

  spwm3_lead_sel #(.LEAD_W(LEAD_W)) u_lead (
    .code   (lead_code),
    .lim_lo (lead_lo),
    .lim_hi (lead_hi),
    .eff    (lead_eff)
  );

  // Base angle: sector start plus position plus lead, modulo one revolution.
  always_comb begin
    base_sum = SUM_W'(sector) * SUM_W'(ANG_SECTOR) + SUM_W'(sector_pos) + SUM_W'(lead_eff);
    if (base_sum >= SUM_W'(ANG_FULL)) begin
      base_ang = ANG_W'(base_sum - SUM_W'(ANG_FULL));
    end else begin
      base_ang = ANG_W'(base_sum);
    end
  end

  // One duty calculator per phase; V lags U by 120 degrees, W by 240.
  for (genvar p = 0; p < NPH; p++) begin : g_phase
    localparam int PH_OFF = (p == 0) ? 0 : ((p == 1) ? 2 * ANG_FULL / 3 : ANG_FULL / 3);
    spwm3_phase_duty #(
      .CNT_W  (CNT_W),
      .AMP_W  (AMP_W),
      .OFFSET (PH_OFF)
    ) u_duty (
      .base (base_ang),
      .amp  (amp_cmd),
      .duty (duty_new[p])
    );

    // R6: the applied duty changes only at the carrier valley
    a_r6_duty_valley_only: assert property (@(posedge clk) disable iff (!rst_n)
      !valley_load |=> $stable(duty_q[p]));
  end

  always_comb begin
    if (amp_cmd == '0) begin
      mode_new = MODE_OFF;
    end else if (amp_cmd < AMP_W'(REFRESH_TOP)) begin
      mode_new = MODE_REFRESH;
    end else begin
      mode_new = MODE_DRIVE;
    end
  end

  // Valley-loaded shadow registers.
  always_comb begin
    mode_d = mode_q;
    duty_d = duty_q;
    if (valley_load) begin
      mode_d = mode_new;
      duty_d = duty_new;
    end
  end

  // Comparators and refresh pulse.
  always_comb begin
    for (int p = 0; p < NPH; p++) begin
      hs_d[p] = (mode_q == MODE_DRIVE) && ({1'b0, cnt} < duty_q[p]);
    end
    ls_d = (mode_q == MODE_REFRESH) && (cnt < CNT_W'(REFRESH_DUTY));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      duty_q <= '0;
      hs_q   <= '0;
      ls_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      duty_q <= duty_d;
      hs_q   <= hs_d;
      ls_q   <= ls_d;
    end
  end

  assign hs_en_u    = hs_q[0];
  assign hs_en_v    = hs_q[1];
  assign hs_en_w    = hs_q[2];
  assign ls_refresh = ls_q;
  assign carrier    = cnt;

  // R4: with ordered limits the effective code lies inside them
  a_r4_clamp_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_lo <= lead_hi) |-> ((lead_eff >= lead_lo) && (lead_eff <= lead_hi)));

  // R4: with inverted limits the lower limit wins
  a_r4_inverted_limits: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_lo > lead_hi) |-> (lead_eff == lead_lo));

  // R7: once the off mode is latched, no enable is driven
  a_r7_off_all_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF) |=> (hs_q == '0) && !ls_q);

  // R8: refresh pulse and high-side drive never coexist
  a_r8_refresh_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ls_q |-> (hs_q == '0));

endmodule

// File: tb/spwm3_gen_bench.sv
module spwm3_gen_bench;

  localparam int PERIOD = 252;

  logic       clk;
  logic       rst_n;
  logic [5:0] amp_cmd;
  logic [4:0] lead_code, lead_lo, lead_hi;
  logic [2:0] sector;
  logic [4:0] sector_pos;
  logic       hs_en_u, hs_en_v, hs_en_w, ls_refresh;
  logic [5:0] carrier;

  int n_checks;
  int n_errors;

  spwm3_gen u_spwm3_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .amp_cmd    (amp_cmd),
    .lead_code  (lead_code),
    .lead_lo    (lead_lo),
    .lead_hi    (lead_hi),
    .sector     (sector),
    .sector_pos (sector_pos),
    .hs_en_u    (hs_en_u),
    .hs_en_v    (hs_en_v),
    .hs_en_w    (hs_en_w),
    .ls_refresh (ls_refresh),
    .carrier    (carrier)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // High clocks per period for a duty d (R3).
  function automatic int on_clocks(input int d);
    if (d <= 0) return 0;
    if (d >= 64) return PERIOD;
    return 4 * d - 2;
  endfunction

  task automatic apply(input int amp, input int code, input int lo, input int hi,
                       input int sec, input int pos);
    @(negedge clk);
    amp_cmd    = 6'(amp);
    lead_code  = 5'(code);
    lead_lo    = 5'(lo);
    lead_hi    = 5'(hi);
    sector     = 3'(sec);
    sector_pos = 5'(pos);
  endtask

  task automatic measure(output int nu, output int nv, output int nw, output int nr);
    nu = 0; nv = 0; nw = 0; nr = 0;
    repeat (2 * PERIOD + 8) @(negedge clk);
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      nu += int'(hs_en_u);
      nv += int'(hs_en_v);
      nw += int'(hs_en_w);
      nr += int'(ls_refresh);
    end
  endtask

  task automatic wait_carrier(input int v);
    do @(negedge clk); while (int'(carrier) != v);
  endtask

  task automatic run_case(input string tag, input int amp, input int code, input int lo,
                          input int hi, input int sec, input int pos,
                          input int du, input int dv, input int dw, input int rf);
    int nu, nv, nw, nr;
    apply(amp, code, lo, hi, sec, pos);
    measure(nu, nv, nw, nr);
    check({tag, " phase U"}, nu, on_clocks(du));
    check({tag, " phase V"}, nv, on_clocks(dv));
    check({tag, " phase W"}, nw, on_clocks(dw));
    check({tag, " refresh"}, nr, rf);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    apply(63, 0, 0, 31, 1, 16);
    repeat (3) @(negedge clk);
    check("R9 reset hs_en_u", int'(hs_en_u), 0);
    check("R9 reset hs_en_v", int'(hs_en_v), 0);
    check("R9 reset hs_en_w", int'(hs_en_w), 0);
    check("R9 reset ls_refresh", int'(ls_refresh), 0);
    check("R9 reset carrier", int'(carrier), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_carrier;
    int len, peak, prev;
    wait_carrier(1);
    wait_carrier(0);
    len = 0; peak = 0; prev = 0;
    // Count clocks from this valley entry to the next one.
    do begin
      @(negedge clk);
      len++;
      if (int'(carrier) > peak) peak = int'(carrier);
      prev = int'(carrier);
    end while (!(int'(carrier) == 0 && len > 2));
    check("R1 carrier period", len, PERIOD);
    check("R1 carrier peak", peak, 63);
  endtask

  task automatic t_angles;
    // R2 R3: 90 degrees, U at peak, V and W at -30 / -150 degrees.
    run_case("R3 angle90", 63, 0, 0, 31, 1, 16, 63, 17, 17, 0);
    // R2: angle 0, V at 240 deg, W at 120 deg.
    run_case("R2 angle0", 63, 0, 0, 31, 0, 0, 32, 5, 59, 0);
    // R2: sector 5 + pos 16 + lead 16 wraps to angle 0.
    run_case("R2 wrap", 63, 16, 0, 31, 5, 16, 32, 5, 59, 0);
  endtask

  task automatic t_lead;
    // R5: code 16 advances angle 0 to 30 deg.
    run_case("R5 lead16", 63, 16, 0, 31, 0, 0, 47, 1, 47, 0);
    // R5: code 31 plus pos 1 reaches 60 deg.
    run_case("R5 lead31", 63, 31, 0, 31, 0, 1, 59, 5, 32, 0);
    // R4: code above the upper limit clamps to 16.
    run_case("R4 clamp hi", 63, 31, 0, 16, 0, 0, 47, 1, 47, 0);
    // R4: code below the lower limit clamps to 16.
    run_case("R4 clamp lo", 63, 2, 16, 20, 0, 0, 47, 1, 47, 0);
    // R4: inverted limits force the lower limit.
    run_case("R4 inverted", 63, 0, 16, 4, 0, 0, 47, 1, 47, 0);
  endtask

  task automatic t_amplitude;
    run_case("R3 amp32", 32, 0, 0, 31, 1, 16, 47, 25, 25, 0);
    run_case("R8 amp8 drive", 8, 0, 0, 31, 1, 16, 35, 31, 31, 0);
    run_case("R8 amp7 refresh", 7, 0, 0, 31, 1, 16, 0, 0, 0, 22);
    run_case("R8 amp1 refresh", 1, 0, 0, 31, 1, 16, 0, 0, 0, 22);
    run_case("R7 amp0 off", 0, 0, 0, 31, 1, 16, 0, 0, 0, 0);
  endtask

  task automatic t_valley_load;
    int nu, nv, nw, nr;
    run_case("R6 preload", 63, 0, 0, 31, 1, 16, 63, 17, 17, 0);
    wait_carrier(63);
    apply(0, 0, 0, 31, 1, 16);
    wait_carrier(40);
    check("R6 change held until valley", int'(hs_en_u), 1);
    wait_carrier(0);
    wait_carrier(20);
    check("R6 change applied after valley", int'(hs_en_u), 0);
    check("R7 refresh off after valley", int'(ls_refresh), 0);
    measure(nu, nv, nw, nr);
    check("R7 amp0 phase U period", nu, 0);
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    t_reset();
    t_carrier();
    t_angles();
    t_lead();
    t_amplitude();
    t_valley_load();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule